// File: doc/BRIEF.md
# Auto-Incrementing Register Burst Sequencer

This block turns a received control-channel message into a series of accesses on a small register file. The first byte of a message selects the operation, the second gives a starting register address, and the accesses that follow work upward from that address. The address moves on by one after each access, so one message can reach a run of neighbouring registers. In a write message every later byte is stored at the current address as soon as it arrives. In a read message the transmitter asks for bytes one at a time, and each request reads the current register and hands its contents out on the next cycle.

A message can fail partway through. If it reaches an address that the register file marks as unusable, the block raises a one-cycle abort and performs no access there. Every access made earlier in that message stands. The same abort is raised for a bad command byte and for a data byte that arrives during a read, and in those cases no register is touched. After an abort the block ignores the rest of the message. An end-of-message marker always returns the block to waiting for a command. If that marker arrives before the command is complete, nothing happens at all.

Top module: `reg_burst_seq`

## Requirements
- R1: After reset the block waits for a command byte, with `regWrEn`, `regRdEn`, `abort` and `txValid` all low.
- R2: A first byte of 0x81 opens a write message and 0x01 opens a read message. Any other first byte raises `abort` in the same cycle and changes no register. All further bytes and read requests are ignored until end of message.
- R3: The second accepted byte of a write or read message becomes the starting register address, presented on `regAddr`.
- R4: In a write message, each data byte with `regAddrOk` high drives `regWrEn` high in the cycle that byte is accepted, with `regWrData` equal to the byte. The address then advances by one, modulo 256 (0xFF is followed by 0x00).
- R5: In a read message, a `txReq` with `regAddrOk` high drives `regRdEn` high in that cycle. `txByte` then equals the register contents with `txValid` high for one cycle on the next cycle, and the address advances by one.
- R6: A write byte or read request at an address with `regAddrOk` low performs no access and raises `abort` for one cycle. Accesses made earlier in the same message stay in effect, and the rest of the message is ignored.
- R7: A data byte received during a read message is an invalid sequence. It raises `abort`, performs no access, and the rest of the message is ignored. It takes precedence over a `txReq` in the same cycle.
- R8: An end of message after only the command byte, or after only the command and address bytes, returns the block to waiting for a command with no access and no abort.
- R9: `rxEom` takes precedence over a data byte or a `txReq` in the same cycle. That byte or request causes no access and no abort.
- R10: A `txReq` outside the data phase of a read message produces neither `regRdEn` nor `txValid`.
- R11: After any end of message, the next accepted byte is decoded as a fresh command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxValid | input | 1 | A received byte is accepted this cycle |
| rxByte | input | 8 | Received byte |
| rxEom | input | 1 | End of message detected this cycle |
| txReq | input | 1 | Transmitter requests the next read byte |
| txByte | output | 8 | Read data for the transmitter |
| txValid | output | 1 | `txByte` is valid (one cycle) |
| abort | output | 1 | One-cycle abort of the current message |
| regAddr | output | 8 | Current register address |
| regWrData | output | 8 | Write data to the register file |
| regWrEn | output | 1 | Register write strobe |
| regRdEn | output | 1 | Register read strobe |
| regRdData | input | 8 | Register contents at `regAddr` |
| regAddrOk | input | 1 | `regAddr` names a usable register |

## Verification
The end-of-message marker can coincide with an access: a data byte in a write message, or a transmitter request in a read message. The bench raises `rxEom` in the same cycle as the byte or the request. It then confirms that the register model kept its old value, that no abort was counted, and that no read byte came out. A second collision is a data byte and a read request arriving together in a read message. The bench provokes it and expects an abort with no read strobe. Address-boundary bursts that cross the unusable window and the 0xFF wrap are compared, register by register, against a shadow copy computed in the bench.

// File: rtl/reg_seq_pkg.sv
package reg_seq_pkg;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_WR,
    ST_RD,
    ST_DRAIN
  } seqState_t;

  typedef struct packed {
    logic loadAddr;
    logic incAddr;
    logic captureRd;
  } dpStrobe_t;

endpackage

// File: rtl/reg_seq_ctrl.sv
module reg_seq_ctrl
  import reg_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CMD_WRITE = 8'h81,
  parameter logic [DATA_W-1:0] CMD_READ  = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxEom,
  input  logic              txReq,
  input  logic              addrOk,
  output dpStrobe_t         strobe,
  output logic              wrEn,
  output logic              rdEn,
  output logic              abortPulse
);

  seqState_t state, stateNext;
  logic isWrite, isWriteNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CMD;
      isWrite <= 1'b0;
    end else begin
      state   <= stateNext;
      isWrite <= isWriteNext;
    end
  end

  always_comb begin
    stateNext   = state;
    isWriteNext = isWrite;
    strobe      = '0;
    wrEn        = 1'b0;
    rdEn        = 1'b0;
    abortPulse  = 1'b0;
    if (rxEom) begin
      // end of message wins over anything else in this cycle
      stateNext = ST_CMD;
    end else begin
      unique case (state)
        ST_CMD: begin
          if (rxValid) begin
            if (rxByte == CMD_WRITE) begin
              stateNext   = ST_ADDR;
              isWriteNext = 1'b1;
            end else if (rxByte == CMD_READ) begin
              stateNext   = ST_ADDR;
              isWriteNext = 1'b0;
            end else begin
              abortPulse = 1'b1;
              stateNext  = ST_DRAIN;
            end
          end
        end
        ST_ADDR: begin
          if (rxValid) begin
            strobe.loadAddr = 1'b1;
            stateNext       = isWrite ? ST_WR : ST_RD;
          end
        end
        ST_WR: begin
          if (rxValid) begin
            if (addrOk) begin
              wrEn           = 1'b1;
              strobe.incAddr = 1'b1;
            end else begin
              abortPulse = 1'b1;
              stateNext  = ST_DRAIN;
            end
          end
        end
        ST_RD: begin
          if (rxValid) begin
            // host may not send data while the block is replying
            abortPulse = 1'b1;
            stateNext  = ST_DRAIN;
          end else if (txReq) begin
            if (addrOk) begin
              rdEn             = 1'b1;
              strobe.incAddr   = 1'b1;
              strobe.captureRd = 1'b1;
            end else begin
              abortPulse = 1'b1;
              stateNext  = ST_DRAIN;
            end
          end
        end
        default: ; // ST_DRAIN: wait for end of message
      endcase
    end
  end

endmodule

// File: rtl/reg_seq_dp.sv
module reg_seq_dp
  import reg_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] txByte,
  output logic              txValid
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr <= '0;
    end else if (strobe.loadAddr) begin
      addr <= rxByte[ADDR_W-1:0];
    end else if (strobe.incAddr) begin
      addr <= addr + ADDR_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txByte  <= '0;
      txValid <= 1'b0;
    end else begin
      txValid <= strobe.captureRd;
      if (strobe.captureRd) txByte <= rdData;
    end
  end

endmodule

// File: rtl/reg_burst_seq.sv
module reg_burst_seq
  import reg_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CMD_WRITE = 8'h81,
  parameter logic [DATA_W-1:0] CMD_READ  = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxEom,
  input  logic              txReq,
  output logic [DATA_W-1:0] txByte,
  output logic              txValid,
  output logic              abort,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData,
  input  logic              regAddrOk
);

  dpStrobe_t strobe;

  reg_seq_ctrl #(
    .DATA_W(DATA_W), .CMD_WRITE(CMD_WRITE), .CMD_READ(CMD_READ)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .rxEom(rxEom), .txReq(txReq), .addrOk(regAddrOk), .strobe(strobe),
    .wrEn(regWrEn), .rdEn(regRdEn), .abortPulse(abort)
  );

  reg_seq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .rdData(regRdData), .addr(regAddr), .txByte(txByte), .txValid(txValid)
  );

  assign regWrData = rxByte;

endmodule

// File: rtl/reg_burst_seq_chk.sv
module reg_burst_seq_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEom,
  input logic [DATA_W-1:0] txByte,
  input logic              txValid,
  input logic              abort,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [DATA_W-1:0] regRdData,
  input logic              regAddrOk
);

  p_access_ok_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn || regRdEn) |-> regAddrOk);

  p_abort_no_access_r6: assert property (@(posedge clk) disable iff (!rstN)
    abort |-> !(regWrEn || regRdEn));

  p_wr_advance_r4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regAddr == ADDR_W'($past(regAddr) + 1'b1)));

  p_rd_reply_r5: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> (txValid && txByte == $past(regRdData)));

  p_tx_from_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(regRdEn));

  p_eom_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxEom |-> !(regWrEn || regRdEn || abort));

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

endmodule

bind reg_burst_seq reg_burst_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .rxEom(rxEom), .txByte(txByte), .txValid(txValid),
  .abort(abort), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regRdData(regRdData), .regAddrOk(regAddrOk)
);

// File: tb/reg_burst_seq_tb_top.sv
module reg_burst_seq_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       rxEom = 1'b0;
  logic       txReq = 1'b0;
  logic [7:0] txByte;
  logic       txValid;
  logic       abort;
  logic [7:0] regAddr;
  logic [7:0] regWrData;
  logic       regWrEn;
  logic       regRdEn;
  logic [7:0] regRdData;
  logic       regAddrOk;

  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  int wrCnt = 0, rdCnt = 0, abortCnt = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  reg_burst_seq dut_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte), .rxEom(rxEom),
    .txReq(txReq), .txByte(txByte), .txValid(txValid), .abort(abort),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regRdData(regRdData), .regAddrOk(regAddrOk)
  );

  // register file model: 0xA0..0xAF is the unusable window
  function automatic bit addrUsable(input logic [7:0] a);
    return a[7:4] != 4'hA;
  endfunction

  assign regRdData = mem[regAddr];
  assign regAddrOk = addrUsable(regAddr);

  always @(posedge clk) begin
    if (regWrEn) begin
      mem[regAddr] <= regWrData;
      wrCnt++;
    end
    if (regRdEn) rdCnt++;
    if (abort) abortCnt++;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); rxValid = 1'b1; rxByte = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic sendEom();
    @(negedge clk); rxEom = 1'b1;
    @(negedge clk); rxEom = 1'b0;
  endtask

  task automatic pullByte(output bit got, output logic [7:0] data);
    @(negedge clk); txReq = 1'b1;
    @(negedge clk); txReq = 1'b0;
    got = txValid; data = txByte;
  endtask

  function automatic logic [7:0] readPattern(input logic [7:0] a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic memMismatches(output int n);
    n = 0;
    for (int a = 0; a < 256; a++) if (mem[a] !== shadow[a]) n++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = ~8'(a);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "txValid", int'(txValid), 0);
    check("R1", "strobes", int'(regWrEn) + int'(regRdEn) + int'(abort), 0);

    // R10 request while idle
    begin
      bit got; logic [7:0] d; int r0;
      r0 = rdCnt;
      pullByte(got, d);
      check("R10", "idle txValid", int'(got), 0);
      check("R10", "idle reads", rdCnt - r0, 0);
    end

    // R2 / R8 / R11 sweep over every command byte
    for (int c = 0; c < 256; c++) begin
      int a0, w0, expAb;
      a0 = abortCnt; w0 = wrCnt;
      sendByte(8'(c));
      if (c != 8'h81 && c != 8'h01) begin
        sendByte(8'h81); sendByte(8'h10); sendByte(8'h55);
        expAb = 1;
      end else expAb = 0;
      sendEom();
      check("R2", $sformatf("abort for cmd %02h", c), abortCnt - a0, expAb);
      check("R8", $sformatf("no write for cmd %02h", c), wrCnt - w0, 0);
    end

    // R8 end after address; R11 fresh message then works; R3 start address
    begin
      int w0, a0;
      w0 = wrCnt; a0 = abortCnt;
      sendByte(8'h81); sendByte(8'h20); sendEom();
      check("R8", "eom after address writes", wrCnt - w0, 0);
      check("R8", "eom after address abort", abortCnt - a0, 0);
      sendByte(8'h81); sendByte(8'h20); sendByte(8'h5A); sendEom();
      check("R3", "write at start address", int'(mem[8'h20]), 8'h5A);
      check("R11", "one write", wrCnt - w0, 1);
    end

    // R4 / R6 write bursts, including window crossing and wrap
    foreach (shadow[a]) shadow[a] = mem[a];
    for (int s = 0; s < 4; s++) begin
      logic [7:0] start;
      start = (s == 0) ? 8'h00 : (s == 1) ? 8'h9C : (s == 2) ? 8'hFD : 8'h3F;
      for (int len = 1; len <= 6; len++) begin
        int a0, expAb, n;
        bit stopped;
        a0 = abortCnt; expAb = 0; stopped = 1'b0;
        sendByte(8'h81); sendByte(start);
        for (int k = 0; k < len; k++) begin
          logic [7:0] a, d;
          a = 8'(start + k);
          d = 8'(start * 3 + k * 5 + len);
          sendByte(d);
          if (!stopped) begin
            if (addrUsable(a)) shadow[a] = d;
            else begin stopped = 1'b1; expAb = 1; end
          end
        end
        sendEom();
        memMismatches(n);
        check(stopped ? "R6" : "R4", $sformatf("regs after burst %02h len %0d", start, len), n, 0);
        check("R6", $sformatf("abort burst %02h len %0d", start, len), abortCnt - a0, expAb);
      end
    end

    // R5 / R6 read bursts
    for (int a = 0; a < 256; a++) mem[a] = readPattern(8'(a));
    for (int s = 0; s < 3; s++) begin
      logic [7:0] start;
      bit stopped;
      int a0, expAb;
      start = (s == 0) ? 8'h10 : (s == 1) ? 8'h9E : 8'hFE;
      stopped = 1'b0; a0 = abortCnt; expAb = 0;
      sendByte(8'h01); sendByte(start);
      for (int k = 0; k < 4; k++) begin
        bit got; logic [7:0] d, a;
        a = 8'(start + k);
        pullByte(got, d);
        if (!stopped && addrUsable(a)) begin
          check("R5", $sformatf("txValid at %02h", a), int'(got), 1);
          check("R5", $sformatf("data at %02h", a), int'(d), int'(readPattern(a)));
        end else begin
          if (!stopped) expAb = 1;
          stopped = 1'b1;
          check("R6", $sformatf("no reply at %02h", a), int'(got), 0);
        end
      end
      sendEom();
      check("R6", $sformatf("abort read %02h", start), abortCnt - a0, expAb);
    end

    // R7 data byte during read
    begin
      int a0, w0, r0; bit got; logic [7:0] d;
      a0 = abortCnt; w0 = wrCnt;
      sendByte(8'h01); sendByte(8'h40); sendByte(8'hEE);
      r0 = rdCnt;
      pullByte(got, d);
      sendEom();
      check("R7", "abort on data in read", abortCnt - a0, 1);
      check("R7", "no write", wrCnt - w0, 0);
      check("R7", "drained request", int'(got) + (rdCnt - r0), 0);
    end

    // R7 data byte and request together
    begin
      int a0, r0;
      sendByte(8'h01); sendByte(8'h41);
      a0 = abortCnt; r0 = rdCnt;
      @(negedge clk); rxValid = 1'b1; rxByte = 8'hFF; txReq = 1'b1;
      @(negedge clk); rxValid = 1'b0; txReq = 1'b0;
      check("R7", "collision abort", abortCnt - a0, 1);
      check("R7", "collision no read", rdCnt - r0, 0);
      check("R7", "collision txValid", int'(txValid), 0);
      sendEom();
    end

    // R10 request during write data phase
    begin
      bit got; logic [7:0] d; int r0;
      sendByte(8'h81); sendByte(8'h50);
      r0 = rdCnt;
      pullByte(got, d);
      check("R10", "request in write", int'(got) + (rdCnt - r0), 0);
      sendEom();
    end

    // R9 end of message together with data byte / request
    begin
      int w0, a0, r0; logic [7:0] old;
      old = mem[8'h30];
      sendByte(8'h81); sendByte(8'h30);
      w0 = wrCnt; a0 = abortCnt;
      @(negedge clk); rxValid = 1'b1; rxByte = 8'h77; rxEom = 1'b1;
      @(negedge clk); rxValid = 1'b0; rxEom = 1'b0;
      check("R9", "eom+byte writes", wrCnt - w0, 0);
      check("R9", "eom+byte reg kept", int'(mem[8'h30]), int'(old));
      check("R9", "eom+byte abort", abortCnt - a0, 0);
      sendByte(8'h01); sendByte(8'h31);
      r0 = rdCnt;
      @(negedge clk); txReq = 1'b1; rxEom = 1'b1;
      @(negedge clk); txReq = 1'b0; rxEom = 1'b0;
      check("R9", "eom+request txValid", int'(txValid), 0);
      check("R9", "eom+request reads", rdCnt - r0, 0);
      // R11 after that end, a write message decodes normally
      sendByte(8'h81); sendByte(8'h31); sendByte(8'h3C); sendEom();
      check("R11", "write after eom", int'(mem[8'h31]), 8'h3C);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule